// File: doc/BRIEF.md
# Reference-Select Setting Scan Chain

This block holds the reference-tap settings for a multi-step converter's mid and fine quantiser stages. All sub-DAC setting registers form one serial shift path. In normal operation the registers copy the tap decisions made by the decision logic on every active chain-clock edge. A freeze control holds them. A scan path lets test equipment shift in known coarse and mid decisions, so that a later stage can be driven across its whole input range. The same path can shift out the settings the converter was really using at the moment of freezing.

The chain clock is the block clock, optionally inverted. This lets the chain run half a period shifted in application mode, or match the edge of a longer system chain. A final retiming flop on the opposite edge drives the serial output. Each sub-DAC also gets one registered test bit that raises its reference current.

Top module: `refsel_scan_chain`

## Requirements
- R1: While `rst_ni` is low on an active chain edge, every stored setting bit, every boost bit and the serial output become 0.
- R2: With `scan_en_i` low and `fix_i` low, each active edge loads `dec_sel_i` into the stored settings.
- R3: With `fix_i` high, `ref_sel_o` shows the stored settings. With `fix_i` low, it follows `dec_sel_i` directly, with no clock edge needed.
- R4: With `fix_i` high and `scan_en_i` low, the stored settings do not change on any edge, whatever `dec_sel_i` does.
- R5: With `scan_en_i` high, each active edge moves every stored bit from index k to index k+1 and puts `scan_in_i` at index 0. Bit index = sub-DAC number × setting width + bit number. After 128 shifts, the first bit shifted in sits at index 127.
- R6: `scan_en_i` high shifts the chain even when `fix_i` is high.
- R7: `scan_out_o` takes the value of stored bit 127 on the chain-clock edge opposite to the active one.
- R8: With `pol_neg_i` = 0 the active edge is the rising edge of `clk_i`. With `pol_neg_i` = 1 it is the falling edge. The other edge never changes the stored settings. `pol_neg_i` may change only while the chain is holding (R4).
- R9: Settings captured under R2 and then frozen appear at `scan_out_o` highest index first. After k shifts, `scan_out_o` equals captured bit 127−k.
- R10: `boost_o` takes `boost_cfg_i` on each active edge.

Top module ports: `refsel_scan_chain`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous active-low reset, sampled on the active chain edge |
| pol_neg_i | input | 1 | 1 selects the falling edge as the active chain edge |
| scan_en_i | input | 1 | Shift enable; overrides freeze |
| fix_i | input | 1 | Freeze settings and drive outputs from the chain |
| scan_in_i | input | 1 | Serial data into bit index 0 |
| dec_sel_i | input | 128 | Functional tap decisions from the decision logic |
| boost_cfg_i | input | 8 | Reference-current boost request, one bit per sub-DAC |
| ref_sel_o | output | 128 | Tap settings to the reference switches |
| boost_o | output | 8 | Registered boost bits to the sub-DACs |
| scan_out_o | output | 1 | Retimed serial output |

## Verification
Freeze and shift can be asserted in the same cycle. The bench keeps `fix_i` high for the entire force and readout sequences. Any shift that happens there is therefore scan-enable overriding the freeze. The forced vector and every serial-out bit are judged against values that the bench computes itself.

Functional capture and the inactive clock edge can also meet. The bench opens the capture conditions only around the inactive edge. It then freezes the chain and checks that nothing was loaded. The same capture must then land on the next active edge. Both sequences run under each clock polarity.

// File: rtl/refsel_pkg.sv
// Package: shared types for the reference-select scan chain.
// Assumes: nothing beyond IEEE 1800-2017.
package refsel_pkg;

    // Per-edge operation of the setting registers.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } chain_op_e;

    // Scan-enable wins over freeze; freeze wins over functional load.
    function automatic chain_op_e pick_op(input logic scan_en, input logic fix);
        if (scan_en)
            return OP_SHIFT;
        else if (fix)
            return OP_HOLD;
        else
            return OP_LOAD;
    endfunction

endpackage

// File: rtl/refsel_clkctl.sv
// Module: refsel_clkctl
// Derives the chain clock from the block clock and the polarity select.
// Decodes scan-enable and freeze into one operation for all segments.
// Assumes: pol_neg_i changes only while the chain is holding, because
// changing it produces one extra chain edge.
module refsel_clkctl
    import refsel_pkg::*;
(
    input  logic      clk_i,
    input  logic      pol_neg_i,
    input  logic      scan_en_i,
    input  logic      fix_i,
    output logic      chain_clk_o,
    output chain_op_e op_o
);

    // Invert the clock when the falling edge is selected as the active edge.
    assign chain_clk_o = clk_i ^ pol_neg_i;

    // Pick the operation applied on the next active edge.
    always_comb begin
        op_o = pick_op(scan_en_i, fix_i);
    end

endmodule

// File: rtl/refsel_segment.sv
// Module: refsel_segment
// The setting register of one sub-DAC plus its current-boost bit.
// It shifts, loads functional decisions or holds, as op_i selects.
// Assumes: W >= 2; bit 0 receives serial data; bit W-1 feeds the next segment.
module refsel_segment
    import refsel_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         chain_clk_i,
    input  logic         rst_ni,
    input  chain_op_e    op_i,
    input  logic         scan_in_i,
    input  logic [W-1:0] func_i,
    input  logic         boost_cfg_i,
    output logic [W-1:0] q_o,
    output logic         scan_out_o,
    output logic         boost_o
);

    logic [W-1:0] q_r;

    // Setting register: shift, load or hold on each active edge.
    always_ff @(posedge chain_clk_i) begin
        if (!rst_ni)
            q_r <= '0;
        else begin
            case (op_i)
                OP_SHIFT: q_r <= {q_r[W-2:0], scan_in_i};
                OP_LOAD:  q_r <= func_i;
                default:  q_r <= q_r;
            endcase
        end
    end

    // Current-boost test bit, registered on each active edge.
    always_ff @(posedge chain_clk_i) begin
        if (!rst_ni)
            boost_o <= 1'b0;
        else
            boost_o <= boost_cfg_i;
    end

    assign q_o        = q_r;
    assign scan_out_o = q_r[W-1];

    // R5
    shift_entry_chk: assert property (@(posedge chain_clk_i) disable iff (!rst_ni)
        (rst_ni && op_i == OP_SHIFT) |=> q_r[0] == $past(scan_in_i));

    // R5
    shift_move_chk: assert property (@(posedge chain_clk_i) disable iff (!rst_ni)
        (rst_ni && op_i == OP_SHIFT) |=> q_r[W-1:1] == $past(q_r[W-2:0]));

    // R2
    func_load_chk: assert property (@(posedge chain_clk_i) disable iff (!rst_ni)
        (rst_ni && op_i == OP_LOAD) |=> q_r == $past(func_i));

    // R4
    freeze_hold_chk: assert property (@(posedge chain_clk_i) disable iff (!rst_ni)
        (rst_ni && op_i == OP_HOLD) |=> $stable(q_r));

    // R10
    boost_follow_chk: assert property (@(posedge chain_clk_i) disable iff (!rst_ni)
        rst_ni |=> boost_o == $past(boost_cfg_i));

endmodule

// File: rtl/refsel_antiskew.sv
// Module: refsel_antiskew
// Retiming flop at the end of the chain. It samples on the edge opposite
// to the active chain edge, which gives the next chain in the system
// half a period of hold margin.
// Assumes: reset is applied for at least one full clock period.
module refsel_antiskew (
    input  logic chain_clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    // Capture the last chain bit on the opposite edge.
    always_ff @(negedge chain_clk_i) begin
        if (!rst_ni)
            q_o <= 1'b0;
        else
            q_o <= d_i;
    end

    // R7
    retime_chk: assert property (@(negedge chain_clk_i) disable iff (!rst_ni)
        rst_ni |=> q_o == $past(d_i));

endmodule

// File: rtl/refsel_scan_chain.sv
// Module: refsel_scan_chain (top)
// NUM_SUB setting segments of SET_W bits each, joined into one serial chain,
// followed by an opposite-edge retiming flop.
// ref_sel_o shows the chain contents while frozen and the live decisions
// otherwise.
// Assumes: segment i holds bits [i*SET_W +: SET_W]; serial data enters at
// index 0 and leaves from the highest index.
module refsel_scan_chain
    import refsel_pkg::*;
#(
    parameter int NUM_SUB = 8,
    parameter int SET_W   = 16,
    localparam int TOTAL  = NUM_SUB * SET_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pol_neg_i,
    input  logic             scan_en_i,
    input  logic             fix_i,
    input  logic             scan_in_i,
    input  logic [TOTAL-1:0] dec_sel_i,
    input  logic [NUM_SUB-1:0] boost_cfg_i,
    output logic [TOTAL-1:0] ref_sel_o,
    output logic [NUM_SUB-1:0] boost_o,
    output logic             scan_out_o
);

    logic             chain_clk;
    chain_op_e        op;
    logic [TOTAL-1:0] stored;
    logic [NUM_SUB:0] link;

    refsel_clkctl u_clkctl (
        .clk_i       (clk_i),
        .pol_neg_i   (pol_neg_i),
        .scan_en_i   (scan_en_i),
        .fix_i       (fix_i),
        .chain_clk_o (chain_clk),
        .op_o        (op)
    );

    assign link[0] = scan_in_i;

    // One segment per sub-DAC, serially linked.
    for (genvar i = 0; i < NUM_SUB; i++) begin : g_seg
        refsel_segment #(.W(SET_W)) u_seg (
            .chain_clk_i (chain_clk),
            .rst_ni      (rst_ni),
            .op_i        (op),
            .scan_in_i   (link[i]),
            .func_i      (dec_sel_i[i*SET_W +: SET_W]),
            .boost_cfg_i (boost_cfg_i[i]),
            .q_o         (stored[i*SET_W +: SET_W]),
            .scan_out_o  (link[i+1]),
            .boost_o     (boost_o[i])
        );
    end

    refsel_antiskew u_antiskew (
        .chain_clk_i (chain_clk),
        .rst_ni      (rst_ni),
        .d_i         (link[NUM_SUB]),
        .q_o         (scan_out_o)
    );

    // Output select: chain contents when frozen, live decisions otherwise.
    always_comb begin
        ref_sel_o = fix_i ? stored : dec_sel_i;
    end

    // R5
    seg_link_chk: assert property (@(posedge chain_clk) disable iff (!rst_ni)
        (rst_ni && scan_en_i) |=> stored[SET_W] == $past(stored[SET_W-1]));

    // R6
    override_chk: assert property (@(posedge chain_clk) disable iff (!rst_ni)
        (rst_ni && scan_en_i && fix_i) |=> stored[0] == $past(scan_in_i));

endmodule

// File: tb/refsel_scan_chain_tb.sv
`timescale 1ns/1ps
module refsel_scan_chain_tb;

    localparam int NS    = 8;
    localparam int SW    = 16;
    localparam int TOTAL = NS * SW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pol;
    logic             se;
    logic             fix;
    logic             si;
    logic [TOTAL-1:0] dec;
    logic [NS-1:0]    bcfg;
    logic [TOTAL-1:0] sel;
    logic [NS-1:0]    boost;
    logic             so;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic  exp_q[$];
    string req_q[$];
    event  smp_ev;

    always #10 clk = ~clk;

    refsel_scan_chain #(.NUM_SUB(NS), .SET_W(SW)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pol_neg_i   (pol),
        .scan_en_i   (se),
        .fix_i       (fix),
        .scan_in_i   (si),
        .dec_sel_i   (dec),
        .boost_cfg_i (bcfg),
        .ref_sel_o   (sel),
        .boost_o     (boost),
        .scan_out_o  (so)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic act_edge();
        if (pol) @(negedge clk); else @(posedge clk);
    endtask

    task automatic opp_edge();
        if (pol) @(posedge clk); else @(negedge clk);
    endtask

    // One active edge, then one opposite edge, then a settle delay.
    task automatic step();
        act_edge();
        opp_edge();
        #2;
    endtask

    // Driver: shift one bit and optionally queue the expected serial output.
    task automatic shift_bit(input logic b, input bit expect_it,
                             input logic e, input string req);
        se = 1'b1;
        si = b;
        step();
        if (expect_it) begin
            exp_q.push_back(e);
            req_q.push_back(req);
        end
        ->smp_ev;
    endtask

    // Monitor: compare scan_out_o against the scoreboard queue.
    initial begin
        forever begin
            @(smp_ev);
            while (exp_q.size() > 0) begin
                logic  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(so === e, r, {{(TOTAL-1){1'b0}}, so}, {{(TOTAL-1){1'b0}}, e});
            end
        end
    end

    function automatic logic [TOTAL-1:0] make_pat(input logic [31:0] seed);
        logic [31:0] x;
        logic [TOTAL-1:0] v;
        x = seed;
        v = '0;
        for (int i = 0; i < TOTAL/32; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            v[i*32 +: 32] = x;
        end
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [TOTAL-1:0] pat;
        logic [TOTAL-1:0] cap;
        logic [TOTAL-1:0] e_val;
        rst_n = 1'b0; pol = 1'b0; se = 1'b0; fix = 1'b1; si = 1'b0;
        dec = make_pat(32'h1234_5678); bcfg = 8'hFF;
        repeat (4) step();
        rst_n = 1'b1;
        #1;
        // R1: reset state seen while frozen
        chk(sel === '0, "R1 settings", sel, '0);
        chk(so === 1'b0, "R1 scan_out", {{(TOTAL-1){1'b0}}, so}, '0);
        chk(boost === '0, "R1 boost", {{(TOTAL-NS){1'b0}}, boost}, '0);

        for (int p = 0; p < 2; p++) begin
            // Switch polarity only while holding (R8).
            se = 1'b0; fix = 1'b1;
            pol = p[0];
            step();

            // R5 R6: force a pattern with freeze left on
            pat = make_pat(32'hC0DE_0000 + p);
            dec = ~pat;
            for (int s = 0; s < TOTAL; s++)
                shift_bit(pat[TOTAL-1-s], 1'b0, 1'b0, "");
            se = 1'b0;
            chk(sel === pat, "R5 R6 forced settings", sel, pat);
            // R3: frozen output ignores live decisions
            chk(sel !== dec, "R3 frozen output not live", sel, pat);
            // R7: retimed output equals top bit
            chk(so === pat[TOTAL-1], "R7 scan_out top bit",
                {{(TOTAL-1){1'b0}}, so}, {{(TOTAL-1){1'b0}}, pat[TOTAL-1]});

            // R4: hold under changing decisions
            dec = make_pat(32'h0BAD_0001 + p);
            step();
            dec = ~dec;
            step();
            chk(sel === pat, "R4 hold", sel, pat);

            // R3: bypass when not frozen, no edge
            fix = 1'b0;
            #1;
            chk(sel === dec, "R3 bypass", sel, dec);

            // R2: functional capture on active edge
            cap = make_pat(32'hFACE_0010 + p);
            dec = cap;
            step();
            fix = 1'b1;
            #1;
            chk(sel === cap, "R2 capture", sel, cap);
            chk(so === cap[TOTAL-1], "R7 R9 first readout bit",
                {{(TOTAL-1){1'b0}}, so}, {{(TOTAL-1){1'b0}}, cap[TOTAL-1]});

            // R9 R6: read captured settings out serially under freeze
            dec = make_pat(32'h5555_0020 + p);
            for (int k = 1; k <= TOTAL; k++) begin
                if (k < TOTAL)
                    shift_bit(1'b0, 1'b1, cap[TOTAL-1-k], "R9 readout");
                else
                    shift_bit(1'b0, 1'b1, 1'b0, "R9 readout tail");
            end
            se = 1'b0;
            #1;
            chk(sel === '0, "R5 chain flushed", sel, '0);

            // R8: the inactive edge must not load
            e_val = make_pat(32'hEDE0_0030 + p);
            act_edge(); #2;
            fix = 1'b0; dec = e_val;
            opp_edge(); #2;
            fix = 1'b1;
            #1;
            chk(sel === '0, "R8 inactive edge ignored", sel, '0);
            fix = 1'b0;
            act_edge(); #2;
            fix = 1'b1;
            #1;
            chk(sel === e_val, "R8 active edge loads", sel, e_val);
            opp_edge(); #2;

            // R10: boost bits follow configuration
            bcfg = p[0] ? 8'h5A : 8'hC3;
            step();
            chk(boost === bcfg, "R10 boost",
                {{(TOTAL-NS){1'b0}}, boost}, {{(TOTAL-NS){1'b0}}, bcfg});
        end

        #5;
        done = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule